// File: doc/BRIEF.md
# Low-Power Mode Clock Gating Controller

This controller puts a small microcontroller into one of two low-power modes and brings it back out. The CPU asks for a mode with a one-cycle request pulse. In the deep mode the main oscillator is halted. In the light mode only the CPU clock is held. In both modes the controller drives a registered clock enable for each peripheral. Each enable is set from the current mode together with the clock source that peripheral has selected.

A pending interrupt request whose enable flag is set ends either mode. The external interrupt lines are simply part of that request vector. The controller then returns to run, raises a one-cycle wake pulse and gives the CPU its clock back one cycle later. An active-low reset returns it to run at once, without waiting for a clock edge.

Top module: `pdc_top`

## Requirements
- R1: While `rst_n` is low, and as soon as it falls without waiting for a clock edge, `pwr_mode` is 2'b00 (run), every clock enable is 1 and `wake_pulse` is 0.
- R2: In run, a `stop_req` pulse taken while `cpu_on_main` is 1 moves `pwr_mode` to 2'b10 (stop) at the next rising edge. If `stop_req` and `idle_req` come together, stop wins.
- R3: In run, a `stop_req` taken while `cpu_on_main` is 0 is ignored: `pwr_mode` stays 2'b00.
- R4: In run, an `idle_req` pulse moves `pwr_mode` to 2'b01 (idle) at the next rising edge.
- R5: `cpu_clk_en` is 0 whenever the mode is idle or stop. `main_osc_en` is 0 exactly while the mode is stop.
- R6: `bt_clk_en`, `cmp_clk_en` and `wt_clk_en` are 0 in stop and 1 in run and in idle.
- R7: `sio_clk_en` follows `sio_sel`, where 2'b00 = CPU clock, 2'b01 = external shift-clock pin, and 2'b10 or 2'b11 = internal divided clocks. In stop the enable is 1 only for 2'b01. In idle it is 1 for any value except 2'b00. In run it is 1.
- R8: `tc0_clk_en` is 1 in stop only when `tc0_ext` is 1 (external count pin selected). It is 1 in idle and in run.
- R9: In idle or stop, any bit set in both `irq_flags` and `irq_en` returns `pwr_mode` to 2'b00 at the next edge, with `wake_pulse` high for exactly that one cycle. Flags whose enable bit is 0 cause no wake.
- R10: After a wake, `cpu_clk_en` stays 0 during the `wake_pulse` cycle and becomes 1 on the following edge.
- R11: While in idle or stop, `stop_req` and `idle_req` are ignored, and the mode holds until a wake or a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_req | input | 1 | Request to enter stop (one-cycle pulse) |
| idle_req | input | 1 | Request to enter idle (one-cycle pulse) |
| cpu_on_main | input | 1 | 1 when the main clock feeds the CPU |
| irq_flags | input | IRQ_W | Interrupt request flags, external lines included |
| irq_en | input | IRQ_W | Per-request enable flags |
| sio_sel | input | 2 | Serial I/O clock source |
| tc0_ext | input | 1 | Timer/counter 0 counts from its external pin |
| pwr_mode | output | 2 | Current mode: 00 run, 01 idle, 10 stop |
| main_osc_en | output | 1 | Main oscillator enable |
| cpu_clk_en | output | 1 | CPU clock enable |
| bt_clk_en | output | 1 | Basic timer clock enable |
| sio_clk_en | output | 1 | Serial I/O clock enable |
| tc0_clk_en | output | 1 | Timer/counter 0 clock enable |
| cmp_clk_en | output | 1 | Comparator clock enable |
| wt_clk_en | output | 1 | Watch timer clock enable |
| wake_pulse | output | 1 | One-cycle pulse on return to run |

## Verification
Some rules are checked by the assertions on every cycle:
- the CPU and oscillator enables always agree with the mode;
- the stop-mode peripheral enables, including the source-dependent serial rule, hold whenever the mode is stop;
- the wake sequence holds: wake to run, a single-cycle pulse, then the CPU clock one cycle later;
- stop is refused on the subsystem clock, and stop is held while no request is pending.

Other behaviour only the bench's scenarios can show:
- the idle-mode source rules for the serial I/O and timer 0 under each selection;
- masked flags failing to wake the controller;
- requests being ignored while in a low-power mode;
- the asynchronous effect of reset in the middle of stop.

// File: rtl/pdc_pkg.sv
package pdc_pkg;

    typedef enum logic [1:0] {
        PM_RUN  = 2'b00,
        PM_IDLE = 2'b01,
        PM_STOP = 2'b10
    } pmode_e;

    localparam int SIO_SEL_W = 2;
    localparam logic [SIO_SEL_W-1:0] SIO_SRC_CPU = 2'b00;
    localparam logic [SIO_SEL_W-1:0] SIO_SRC_EXT = 2'b01;

    typedef struct packed {
        logic osc;
        logic cpu;
        logic bt;
        logic sio;
        logic tc0;
        logic cmp;
        logic wt;
    } clk_en_t;

    localparam clk_en_t CLK_EN_ALL = '{default: 1'b1};

endpackage

// File: rtl/pdc_wake_detect.sv
module pdc_wake_detect #(
    parameter int IRQ_W = 8
) (
    input  logic [IRQ_W-1:0] irq_flags,
    input  logic [IRQ_W-1:0] irq_en,
    output logic             wake_any
);
    logic [IRQ_W-1:0] armed;

    // one qualifying gate per request line
    for (genvar g = 0; g < IRQ_W; g++) begin : g_line
        assign armed[g] = irq_flags[g] & irq_en[g];
    end

    assign wake_any = |armed;
endmodule

// File: rtl/pdc_mode_fsm.sv
module pdc_mode_fsm
    import pdc_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   stop_req,
    input  logic   idle_req,
    input  logic   cpu_on_main,
    input  logic   wake_any,
    output pmode_e mode_d,
    output pmode_e mode_q,
    output logic   wake_q
);
    typedef struct packed {
        pmode_e mode;
        logic   wake;
    } fsm_t;

    fsm_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.wake = 1'b0;
        unique case (st_q.mode)
            PM_RUN: begin
                if (stop_req && cpu_on_main) begin
                    st_d.mode = PM_STOP;
                end else if (idle_req) begin
                    st_d.mode = PM_IDLE;
                end
            end
            PM_IDLE, PM_STOP: begin
                if (wake_any) begin
                    st_d.mode = PM_RUN;
                    st_d.wake = 1'b1;
                end
            end
            default: st_d.mode = PM_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: PM_RUN, wake: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_d = st_d.mode;
    assign mode_q = st_q.mode;
    assign wake_q = st_q.wake;

    // a pending qualified request always leaves a low-power mode
    AST_WAKE_TO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode != PM_RUN && wake_any) |=> (st_q.mode == PM_RUN && st_q.wake)); // R9
endmodule

// File: rtl/pdc_gate_rules.sv
module pdc_gate_rules
    import pdc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  pmode_e               mode_d,
    input  pmode_e               mode_q,
    input  logic [SIO_SEL_W-1:0] sio_sel,
    input  logic                 tc0_ext,
    output clk_en_t              en_q
);
    clk_en_t en_d;

    always_comb begin
        en_d = CLK_EN_ALL;
        unique case (mode_d)
            PM_IDLE: begin
                en_d.sio = (sio_sel != SIO_SRC_CPU);
            end
            PM_STOP: begin
                en_d.osc = 1'b0;
                en_d.bt  = 1'b0;
                en_d.sio = (sio_sel == SIO_SRC_EXT);
                en_d.tc0 = tc0_ext;
                en_d.cmp = 1'b0;
                en_d.wt  = 1'b0;
            end
            default: ;
        endcase
        // CPU clock comes back only after a full cycle in run
        en_d.cpu = (mode_d == PM_RUN) && (mode_q == PM_RUN);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= CLK_EN_ALL;
        end else begin
            en_q <= en_d;
        end
    end

    AST_STOP_SIO_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == PM_STOP && $past(sio_sel) != SIO_SRC_EXT) |-> !en_q.sio); // R7
endmodule

// File: rtl/pdc_top.sv
module pdc_top
    import pdc_pkg::*;
#(
    parameter int IRQ_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 stop_req,
    input  logic                 idle_req,
    input  logic                 cpu_on_main,
    input  logic [IRQ_W-1:0]     irq_flags,
    input  logic [IRQ_W-1:0]     irq_en,
    input  logic [SIO_SEL_W-1:0] sio_sel,
    input  logic                 tc0_ext,
    output logic [1:0]           pwr_mode,
    output logic                 main_osc_en,
    output logic                 cpu_clk_en,
    output logic                 bt_clk_en,
    output logic                 sio_clk_en,
    output logic                 tc0_clk_en,
    output logic                 cmp_clk_en,
    output logic                 wt_clk_en,
    output logic                 wake_pulse
);
    logic    wake_any;
    pmode_e  mode_d, mode_q;
    clk_en_t en_q;

    pdc_wake_detect #(.IRQ_W(IRQ_W)) i_wake (
        .irq_flags (irq_flags),
        .irq_en    (irq_en),
        .wake_any  (wake_any)
    );

    pdc_mode_fsm i_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .stop_req    (stop_req),
        .idle_req    (idle_req),
        .cpu_on_main (cpu_on_main),
        .wake_any    (wake_any),
        .mode_d      (mode_d),
        .mode_q      (mode_q),
        .wake_q      (wake_pulse)
    );

    pdc_gate_rules i_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_d  (mode_d),
        .mode_q  (mode_q),
        .sio_sel (sio_sel),
        .tc0_ext (tc0_ext),
        .en_q    (en_q)
    );

    assign pwr_mode    = mode_q;
    assign main_osc_en = en_q.osc;
    assign cpu_clk_en  = en_q.cpu;
    assign bt_clk_en   = en_q.bt;
    assign sio_clk_en  = en_q.sio;
    assign tc0_clk_en  = en_q.tc0;
    assign cmp_clk_en  = en_q.cmp;
    assign wt_clk_en   = en_q.wt;

    AST_CPU_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_mode != PM_RUN) |-> !cpu_clk_en); // R5
    AST_OSC_IN_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_mode == PM_STOP) |-> !main_osc_en); // R5
    AST_OSC_OUT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_mode != PM_STOP) |-> main_osc_en); // R5
    AST_STOP_PERIPH_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_mode == PM_STOP) |-> (!bt_clk_en && !cmp_clk_en && !wt_clk_en)); // R6
    AST_STOP_NEEDS_MAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_mode == PM_RUN && stop_req && !cpu_on_main) |=> (pwr_mode != PM_STOP)); // R3
    AST_WAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |=> !wake_pulse); // R9
    AST_CPU_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_pulse && !stop_req && !idle_req) |=> cpu_clk_en); // R10
    AST_LOWPWR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_mode != PM_RUN && !wake_any) |=> (pwr_mode == $past(pwr_mode))); // R11
endmodule

// File: tb/test_pdc_top.sv
module test_pdc_top;
    localparam int IRQ_W = 8;

    typedef struct {
        logic [1:0] mode;
        logic [6:0] en;
        logic       wake;
        string      tag;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             stop_req = 1'b0, idle_req = 1'b0, cpu_on_main = 1'b1;
    logic [IRQ_W-1:0] irq_flags = '0, irq_en = '0;
    logic [1:0]       sio_sel = 2'b00;
    logic             tc0_ext = 1'b0;
    logic [1:0]       pwr_mode;
    logic             main_osc_en, cpu_clk_en, bt_clk_en, sio_clk_en;
    logic             tc0_clk_en, cmp_clk_en, wt_clk_en, wake_pulse;

    int   errors = 0;
    int   checks = 0;
    exp_t exp_q[$];

    always #10 clk = ~clk;

    pdc_top #(.IRQ_W(IRQ_W)) i_pdc_top (
        .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .idle_req(idle_req),
        .cpu_on_main(cpu_on_main), .irq_flags(irq_flags), .irq_en(irq_en),
        .sio_sel(sio_sel), .tc0_ext(tc0_ext), .pwr_mode(pwr_mode),
        .main_osc_en(main_osc_en), .cpu_clk_en(cpu_clk_en), .bt_clk_en(bt_clk_en),
        .sio_clk_en(sio_clk_en), .tc0_clk_en(tc0_clk_en), .cmp_clk_en(cmp_clk_en),
        .wt_clk_en(wt_clk_en), .wake_pulse(wake_pulse)
    );

    // expected enables {osc,cpu,bt,sio,tc0,cmp,wt} from the requirements
    function automatic logic [6:0] rule_en(logic [1:0] m, logic cpu);
        logic [6:0] e;
        case (m)
            2'b01:   e = {1'b1, cpu, 1'b1, sio_sel != 2'b00, 1'b1, 1'b1, 1'b1};
            2'b10:   e = {1'b0, cpu, 1'b0, sio_sel == 2'b01, tc0_ext, 1'b0, 1'b0};
            default: e = {1'b1, cpu, 5'b11111};
        endcase
        return e;
    endfunction

    function automatic void compare(exp_t e);
        logic [6:0] act_en;
        act_en = {main_osc_en, cpu_clk_en, bt_clk_en, sio_clk_en,
                  tc0_clk_en, cmp_clk_en, wt_clk_en};
        checks++;
        if (pwr_mode !== e.mode || act_en !== e.en || wake_pulse !== e.wake) begin
            errors++;
            $display("FAIL %s: mode=%b en=%b wake=%b expected mode=%b en=%b wake=%b",
                     e.tag, pwr_mode, act_en, wake_pulse, e.mode, e.en, e.wake);
        end
    endfunction

    // monitor: compares queued expectations away from the rising edge
    always @(negedge clk) begin
        while (exp_q.size() > 0) compare(exp_q.pop_front());
    end

    // driver: apply inputs for one cycle, push the result due after the edge
    task automatic step(logic sr, logic ir, logic [IRQ_W-1:0] fl,
                        logic [1:0] m, logic cpu, logic wk, string tag);
        exp_t e;
        stop_req  = sr;
        idle_req  = ir;
        irq_flags = fl;
        @(posedge clk);
        #1;
        e.mode = m; e.en = rule_en(m, cpu); e.wake = wk; e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
        stop_req = 1'b0;
        idle_req = 1'b0;
    endtask

    initial begin
        #3_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        exp_t e;
        irq_en = 8'b0000_0100;
        repeat (3) @(negedge clk);
        e.mode = 2'b00; e.en = 7'h7F; e.wake = 1'b0; e.tag = "R1 in reset";
        compare(e);
        rst_n = 1'b1;
        @(negedge clk);

        // idle with serial clock on the CPU clock
        sio_sel = 2'b00; tc0_ext = 1'b0;
        step(0, 1, 8'h00, 2'b01, 0, 0, "R4 R5 R7 R8 enter idle, sio on cpu clk");
        step(1, 0, 8'h00, 2'b01, 0, 0, "R11 stop request in idle ignored");
        step(0, 1, 8'h00, 2'b01, 0, 0, "R11 idle request in idle ignored");
        step(0, 0, 8'hFB, 2'b01, 0, 0, "R9 masked flags give no wake");
        step(0, 0, 8'h04, 2'b00, 0, 1, "R9 enabled flag wakes from idle");
        step(0, 0, 8'h00, 2'b00, 1, 0, "R10 cpu clock back one cycle later");

        // stop with serial clock from pin, timer from internal clock
        sio_sel = 2'b01; tc0_ext = 1'b0; cpu_on_main = 1'b1;
        step(1, 1, 8'h00, 2'b10, 0, 0, "R2 R6 R7 R8 enter stop, stop wins over idle");
        step(0, 1, 8'h00, 2'b10, 0, 0, "R11 stop held, idle ignored");
        step(0, 0, 8'h00, 2'b10, 0, 0, "R11 stop held");
        step(0, 0, 8'h04, 2'b00, 0, 1, "R9 wake from stop");
        step(0, 0, 8'h00, 2'b00, 1, 0, "R10 cpu clock after stop wake");

        // stop refused on subsystem clock
        cpu_on_main = 1'b0;
        step(1, 0, 8'h00, 2'b00, 1, 0, "R3 stop ignored on subsystem clock");
        step(0, 0, 8'h00, 2'b00, 1, 0, "R3 still run");

        // idle with divided serial clock
        sio_sel = 2'b10;
        step(0, 1, 8'h00, 2'b01, 0, 0, "R7 idle with divided sio clock");
        step(0, 0, 8'h04, 2'b00, 0, 1, "R9 wake again");
        step(0, 0, 8'h00, 2'b00, 1, 0, "R10 cpu return");

        // stop with timer on pin, serial on CPU clock
        cpu_on_main = 1'b1; sio_sel = 2'b00; tc0_ext = 1'b1;
        step(1, 0, 8'h00, 2'b10, 0, 0, "R7 R8 stop with timer pin clock");
        step(0, 0, 8'h00, 2'b10, 0, 0, "R6 stop held");

        // asynchronous reset in the middle of stop
        #5;
        rst_n = 1'b0;
        #1;
        e.mode = 2'b00; e.en = 7'h7F; e.wake = 1'b0; e.tag = "R1 async reset in stop";
        compare(e);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        e.tag = "R1 run after reset release";
        compare(e);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule